// File: doc/BRIEF.md
# RC4 Fixed-Block Stream Cipher Engine

This block encrypts or decrypts one 16-byte message under a 3-byte key with the RC4 stream cipher. The two directions are the same operation, because the message is XORed with a keystream that depends only on the key.

The 256-entry permutation table sits in an internal two-port RAM with registered reads. A rising edge on `enable` captures the key and the message. The block then fills the table with the identity permutation and runs the 256-step key schedule. After that it produces 16 keystream bytes and XORs each one into the result.

When the result is final, `done` is high for exactly one cycle. The result then holds until the next operation is accepted. The block is intended as the inner worker of a key-search or message-recovery controller. Such a controller restarts the block once for each candidate key.

Top module: `rc4_stream_xor`

## Requirements
- R1: Message byte n (n = 0..15) is carried in bits [127-8n -: 8] of `msg_in` and `msg_out`. Key schedule byte k uses `key[7:0]`, `key[15:8]`, `key[23:16]` for k mod 3 = 0, 1, 2. The table starts as S[x]=x. For x = 0..255 the schedule sets j = j + S[x] + keybyte and swaps S[x] with S[j]. For each output byte the generator sets i = i+1, sets j = j+S[i], swaps S[i] with S[j], and XORs S[S[i]+S[j]] into the message byte. All sums are modulo 256.
- R2: Key 24'h010203 with message 128'h5745204C4F5645204543454E20333230 yields 128'h5c057e9fd5458ec36d7ef9cc4d22ea3e.
- R3: Feeding a result back in with the same key returns the original message.
- R4: An operation starts only when `enable` is high in a cycle after a cycle in which it was low, and only while the block is idle. Holding `enable` high after completion starts nothing.
- R5: `done` is high for exactly one cycle per operation. That cycle comes 1105 rising clock edges after the start is accepted, counting the accepting edge as the first (1 + 256 + 3·256 + 5·16).
- R6: `msg_out` keeps its value from the `done` cycle until the next accepted start, whatever `key` and `msg_in` do.
- R7: `key` and `msg_in` are captured when the start is accepted. Changing them during an operation has no effect on its result.
- R8: Lowering and raising `enable` during an operation neither restarts nor aborts it, and it completes exactly once.
- R9: Reset is synchronous and active low. It returns the block to idle, clears `done`, zeroes `msg_out`, and abandons any operation in progress, so no `done` follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| enable | input | 1 | Level input; its rising edge starts an operation |
| key | input | 24 | Cipher key, lowest byte used first |
| msg_in | input | 128 | Plaintext or ciphertext, byte 0 in the top bits |
| msg_out | output | 128 | XOR of the message with the keystream |
| done | output | 1 | One-cycle pulse when `msg_out` is final |

## Verification
The bench builds the block with its default parameters: a 16-byte message and a 3-byte key. Every operation therefore runs the full 256-step schedule and a 16-byte keystream. This allows comparison against a known published vector and against an independent model for several keys, including all-zero and all-one corner cases. The fixed 1105-cycle completion time is also checked against these defaults. Because an operation is only about a thousand cycles long, the bench can also fit in a round trip, mid-operation input changes and enable toggles, a long hold with enable left high, and a reset in the middle of a run.

// File: rtl/rc4_pkg.sv
// Package: shared types for the RC4 block engine.
// Assumes an 8-bit symbol and a 256-entry permutation table.
package rc4_pkg;

    localparam int SYM_W       = 8;
    localparam int TABLE_DEPTH = 256;

    typedef logic [SYM_W-1:0] rc4_sym_t;

    typedef enum logic [3:0] {
        PH_IDLE,
        PH_FILL,
        PH_SCH_READ,
        PH_SCH_JUMP,
        PH_SCH_SWAP,
        PH_GEN_STEP,
        PH_GEN_JUMP,
        PH_GEN_SWAP,
        PH_GEN_PICK,
        PH_GEN_XOR,
        PH_FINISH
    } rc4_phase_e;

endpackage

// File: rtl/rc4_sbox_ram.sv
// Module: rc4_sbox_ram
// Two-port table with registered, read-first outputs on both ports.
// Assumes the user never writes one address from both ports in one cycle.
module rc4_sbox_ram #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic              a_we,
    input  logic [DATA_W-1:0] a_wdata,
    output logic [DATA_W-1:0] a_rdata,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic              b_we,
    input  logic [DATA_W-1:0] b_wdata,
    output logic [DATA_W-1:0] b_rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Purpose: apply writes from both ports to the storage array.
    always_ff @(posedge clk) begin
        if (a_we) mem[a_addr] <= a_wdata;
        if (b_we) mem[b_addr] <= b_wdata;
    end

    // Purpose: register the read data of both ports (old contents on a write).
    always_ff @(posedge clk) begin
        a_rdata <= mem[a_addr];
        b_rdata <= mem[b_addr];
    end

endmodule

// File: rtl/rc4_key_pick.sv
// Module: rc4_key_pick
// Selects key byte `sel` from a packed key, byte 0 in the lowest bits.
// Assumes sel stays below KEY_BYTES; other values return zero.
module rc4_key_pick #(
    parameter int KEY_BYTES = 3,
    parameter int SEL_W     = 2
) (
    input  logic [8*KEY_BYTES-1:0] key_bus,
    input  logic [SEL_W-1:0]       sel,
    output rc4_pkg::rc4_sym_t      key_sym
);

    rc4_pkg::rc4_sym_t key_arr [KEY_BYTES];

    for (genvar g = 0; g < KEY_BYTES; g++) begin : g_unpack
        assign key_arr[g] = key_bus[8*g +: 8];
    end

    // Purpose: one-hot style select of the addressed key byte.
    always_comb begin
        key_sym = '0;
        for (int k = 0; k < KEY_BYTES; k++) begin
            if (sel == SEL_W'(k)) key_sym = key_arr[k];
        end
    end

endmodule

// File: rtl/rc4_engine.sv
// Module: rc4_engine
// Sequencer for table fill, key schedule and keystream generation.
// Uses a registered-read two-port table: 1 cycle per fill entry,
// 3 cycles per schedule step, 5 cycles per keystream byte.
// Assumes `start` is only asserted while `idle` is high.
module rc4_engine
    import rc4_pkg::*;
#(
    parameter int MSG_BYTES = 16,
    parameter int KEY_BYTES = 3,
    parameter int POS_W     = (MSG_BYTES > 1) ? $clog2(MSG_BYTES) : 1,
    parameter int KSEL_W    = (KEY_BYTES > 1) ? $clog2(KEY_BYTES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  rc4_sym_t          key_sym,
    output logic [KSEL_W-1:0] key_sel,
    output rc4_sym_t          ram_a_addr,
    output logic              ram_a_we,
    output rc4_sym_t          ram_a_wdata,
    input  rc4_sym_t          ram_a_rdata,
    output rc4_sym_t          ram_b_addr,
    output logic              ram_b_we,
    output rc4_sym_t          ram_b_wdata,
    input  rc4_sym_t          ram_b_rdata,
    output logic              ks_valid,
    output rc4_sym_t          ks_sym,
    output logic [POS_W-1:0]  ks_pos,
    output logic              idle,
    output logic              done
);

    localparam rc4_sym_t LAST_IDX = rc4_sym_t'(TABLE_DEPTH - 1);
    localparam logic [POS_W-1:0]  LAST_POS = POS_W'(MSG_BYTES - 1);
    localparam logic [KSEL_W-1:0] LAST_KEY = KSEL_W'(KEY_BYTES - 1);

    rc4_phase_e        phase_q, phase_d;
    rc4_sym_t          fill_q, i_q, j_q, si_q, t_q;
    logic [KSEL_W-1:0] ksel_q;
    logic [POS_W-1:0]  pos_q;

    rc4_sym_t j_sched, j_gen, i_inc;
    logic     same_slot;

    assign j_sched   = j_q + ram_a_rdata + key_sym;
    assign j_gen     = j_q + ram_a_rdata;
    assign i_inc     = i_q + 8'd1;
    assign same_slot = (i_q == j_q);

    // Purpose: next phase and table port controls for the current phase.
    always_comb begin
        phase_d     = phase_q;
        ram_a_addr  = i_q;
        ram_a_we    = 1'b0;
        ram_a_wdata = ram_b_rdata;
        ram_b_addr  = j_q;
        ram_b_we    = 1'b0;
        ram_b_wdata = si_q;
        ks_valid    = 1'b0;
        unique case (phase_q)
            PH_IDLE: if (start) phase_d = PH_FILL;
            PH_FILL: begin
                ram_a_addr  = fill_q;
                ram_a_we    = 1'b1;
                ram_a_wdata = fill_q;
                if (fill_q == LAST_IDX) phase_d = PH_SCH_READ;
            end
            PH_SCH_READ: phase_d = PH_SCH_JUMP;
            PH_SCH_JUMP: begin
                ram_b_addr = j_sched;
                phase_d    = PH_SCH_SWAP;
            end
            PH_SCH_SWAP: begin
                ram_a_we = 1'b1;
                ram_b_we = !same_slot;
                phase_d  = (i_q == LAST_IDX) ? PH_GEN_STEP : PH_SCH_READ;
            end
            PH_GEN_STEP: begin
                ram_a_addr = i_inc;
                phase_d    = PH_GEN_JUMP;
            end
            PH_GEN_JUMP: begin
                ram_b_addr = j_gen;
                phase_d    = PH_GEN_SWAP;
            end
            PH_GEN_SWAP: begin
                ram_a_we = 1'b1;
                ram_b_we = !same_slot;
                phase_d  = PH_GEN_PICK;
            end
            PH_GEN_PICK: begin
                ram_a_addr = t_q;
                phase_d    = PH_GEN_XOR;
            end
            PH_GEN_XOR: begin
                ks_valid = 1'b1;
                phase_d  = (pos_q == LAST_POS) ? PH_FINISH : PH_GEN_STEP;
            end
            PH_FINISH: phase_d = PH_IDLE;
            default:   phase_d = PH_IDLE;
        endcase
    end

    // Purpose: phase register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= PH_IDLE;
        else        phase_q <= phase_d;
    end

    // Purpose: pointers, captured table values and counters per phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_q <= '0;
            i_q    <= '0;
            j_q    <= '0;
            si_q   <= '0;
            t_q    <= '0;
            ksel_q <= '0;
            pos_q  <= '0;
        end else begin
            unique case (phase_q)
                PH_IDLE: fill_q <= '0;
                PH_FILL: begin
                    fill_q <= fill_q + 8'd1;
                    i_q    <= '0;
                    j_q    <= '0;
                    ksel_q <= '0;
                end
                PH_SCH_JUMP: begin
                    si_q <= ram_a_rdata;
                    j_q  <= j_sched;
                end
                PH_SCH_SWAP: begin
                    i_q    <= i_inc;
                    ksel_q <= (ksel_q == LAST_KEY) ? '0 : ksel_q + 1'b1;
                    if (i_q == LAST_IDX) begin
                        j_q   <= '0;
                        pos_q <= '0;
                    end
                end
                PH_GEN_STEP: i_q <= i_inc;
                PH_GEN_JUMP: begin
                    si_q <= ram_a_rdata;
                    j_q  <= j_gen;
                end
                PH_GEN_SWAP: t_q   <= si_q + ram_b_rdata;
                PH_GEN_XOR:  pos_q <= pos_q + 1'b1;
                default: ;
            endcase
        end
    end

    assign key_sel = ksel_q;
    assign ks_sym  = ram_a_rdata;
    assign ks_pos  = pos_q;
    assign idle    = (phase_q == PH_IDLE);
    assign done    = (phase_q == PH_FINISH);

endmodule

// File: rtl/rc4_stream_xor.sv
// Module: rc4_stream_xor (top)
// RC4 encrypt/decrypt of a fixed-length block. A rising edge of `enable`
// while idle captures key and message; `done` pulses once when the
// result is final, and the result holds until the next accepted start.
// Assumes a single clock and synchronous active-low reset.
module rc4_stream_xor
    import rc4_pkg::*;
#(
    parameter int MSG_BYTES = 16,
    parameter int KEY_BYTES = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   enable,
    input  logic [8*KEY_BYTES-1:0] key,
    input  logic [8*MSG_BYTES-1:0] msg_in,
    output logic [8*MSG_BYTES-1:0] msg_out,
    output logic                   done
);

    localparam int MSG_W  = 8 * MSG_BYTES;
    localparam int KEY_W  = 8 * KEY_BYTES;
    localparam int POS_W  = (MSG_BYTES > 1) ? $clog2(MSG_BYTES) : 1;
    localparam int KSEL_W = (KEY_BYTES > 1) ? $clog2(KEY_BYTES) : 1;
    localparam int ADDR_W = $clog2(TABLE_DEPTH);

    logic              en_q, start, idle;
    logic [KEY_W-1:0]  key_q;
    logic [MSG_W-1:0]  msg_q, res_q;
    logic [KSEL_W-1:0] key_sel;
    rc4_sym_t          key_sym;
    rc4_sym_t          a_addr, a_wdata, a_rdata, b_addr, b_wdata, b_rdata;
    logic              a_we, b_we;
    logic              ks_valid;
    rc4_sym_t          ks_sym;
    logic [POS_W-1:0]  ks_pos;

    assign start = enable && !en_q && idle;

    // Purpose: remember the previous enable level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= enable;
    end

    // Purpose: capture key and message when a start is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            key_q <= '0;
            msg_q <= '0;
        end else if (start) begin
            key_q <= key;
            msg_q <= msg_in;
        end
    end

    // Purpose: write each keystream-masked byte into its result slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
        end else if (ks_valid) begin
            for (int b = 0; b < MSG_BYTES; b++) begin
                if (ks_pos == POS_W'(b))
                    res_q[MSG_W-1-8*b -: 8] <= msg_q[MSG_W-1-8*b -: 8] ^ ks_sym;
            end
        end
    end

    rc4_key_pick #(
        .KEY_BYTES (KEY_BYTES),
        .SEL_W     (KSEL_W)
    ) u_key_pick (
        .key_bus (key_q),
        .sel     (key_sel),
        .key_sym (key_sym)
    );

    rc4_sbox_ram #(
        .ADDR_W (ADDR_W),
        .DATA_W (SYM_W)
    ) u_table (
        .clk     (clk),
        .a_addr  (a_addr),
        .a_we    (a_we),
        .a_wdata (a_wdata),
        .a_rdata (a_rdata),
        .b_addr  (b_addr),
        .b_we    (b_we),
        .b_wdata (b_wdata),
        .b_rdata (b_rdata)
    );

    rc4_engine #(
        .MSG_BYTES (MSG_BYTES),
        .KEY_BYTES (KEY_BYTES),
        .POS_W     (POS_W),
        .KSEL_W    (KSEL_W)
    ) u_engine (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .key_sym     (key_sym),
        .key_sel     (key_sel),
        .ram_a_addr  (a_addr),
        .ram_a_we    (a_we),
        .ram_a_wdata (a_wdata),
        .ram_a_rdata (a_rdata),
        .ram_b_addr  (b_addr),
        .ram_b_we    (b_we),
        .ram_b_wdata (b_wdata),
        .ram_b_rdata (b_rdata),
        .ks_valid    (ks_valid),
        .ks_sym      (ks_sym),
        .ks_pos      (ks_pos),
        .idle        (idle),
        .done        (done)
    );

    assign msg_out = res_q;

endmodule

// File: rtl/rc4_stream_xor_checker.sv
// Module: rc4_stream_xor_checker
// Port-level protocol checks for rc4_stream_xor, attached with bind.
// Tracks accepted starts from enable edges and the done pulse only.
module rc4_stream_xor_checker #(
    parameter int MSG_BYTES = 16
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   enable,
    input logic                   done,
    input logic [8*MSG_BYTES-1:0] msg_out
);

    localparam int LATENCY = 1 + 256 + 3 * 256 + 5 * MSG_BYTES;

    logic        en_prev_q, busy_q, hold_q;
    logic [15:0] lat_q;
    logic        rise;

    assign rise = enable && !en_prev_q;

    // Purpose: mirror the accepted-start and hold intervals from the ports.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_prev_q <= 1'b0;
            busy_q    <= 1'b0;
            hold_q    <= 1'b0;
            lat_q     <= '0;
        end else begin
            en_prev_q <= enable;
            if (done)                 busy_q <= 1'b0;
            else if (rise && !busy_q) busy_q <= 1'b1;
            if (rise && !busy_q)       lat_q <= 16'd1;
            else if (busy_q && lat_q != 16'hFFFF) lat_q <= lat_q + 16'd1;
            if (done)                 hold_q <= 1'b1;
            else if (rise)            hold_q <= 1'b0;
        end
    end

    assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (busy_q && lat_q == 16'(LATENCY)));

    assert_done_needs_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy_q);

    assert_result_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        hold_q |-> $stable(msg_out));

    assert_reset_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!done && msg_out == '0));

endmodule

bind rc4_stream_xor rc4_stream_xor_checker #(.MSG_BYTES(MSG_BYTES)) u_check (
    .clk     (clk),
    .rst_n   (rst_n),
    .enable  (enable),
    .done    (done),
    .msg_out (msg_out)
);

// File: tb/rc4_stream_xor_bench.sv
// Bench for rc4_stream_xor: a vector table walked by one loop, then
// directed tests for reset, holding, input changes and enable toggles.
module rc4_stream_xor_bench;

    localparam int LAT = 1105;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         enable = 1'b0;
    logic [23:0]  key = '0;
    logic [127:0] msg_in = '0;
    logic [127:0] msg_out;
    logic         done;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    rc4_stream_xor u_rc4_stream_xor (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (enable),
        .key     (key),
        .msg_in  (msg_in),
        .msg_out (msg_out),
        .done    (done)
    );

    localparam logic [23:0]  VKEY [5] = '{24'h3fe21b, 24'h000000, 24'hffffff,
                                         24'h030201, 24'h5a5aa5};
    localparam logic [127:0] VMSG [5] = '{128'h0f844e5b0b4e42d35d063c6a1a5a1524,
                                         128'h0,
                                         {16{8'hff}},
                                         128'h5745204C4F5645204543454E20333230,
                                         128'h0123456789abcdeffedcba9876543210};

    // Independent model of the cipher from the requirement text (R1).
    function automatic logic [127:0] model(input logic [23:0] k, input logic [127:0] m);
        logic [7:0]   s [256];
        logic [7:0]   j, t, i;
        logic [127:0] r;
        for (int n = 0; n < 256; n++) s[n] = 8'(n);
        j = 8'd0;
        for (int n = 0; n < 256; n++) begin
            j = j + s[n] + k[8*(n%3) +: 8];
            t = s[n]; s[n] = s[j]; s[j] = t;
        end
        i = 8'd0; j = 8'd0; r = '0;
        for (int n = 0; n < 16; n++) begin
            i = i + 8'd1;
            j = j + s[i];
            t = s[i]; s[i] = s[j]; s[j] = t;
            t = s[i] + s[j];
            r[127-8*n -: 8] = m[127-8*n -: 8] ^ s[t];
        end
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input logic [127:0] act,
                         input logic [127:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Raise enable at a falling edge with new inputs.
    task automatic begin_op(input logic [23:0] k, input logic [127:0] m);
        @(negedge clk);
        key = k; msg_in = m; enable = 1'b1;
    endtask

    // Count rising edges until done is seen high (sampled at falling edges).
    task automatic wait_done(output int edges);
        edges = 0;
        for (int c = 0; c < 3000; c++) begin
            @(posedge clk); edges++;
            @(negedge clk);
            if (done) return;
        end
        edges = -1;
    endtask

    // Count done pulses over a number of cycles.
    task automatic count_done(input int cycles, output int pulses);
        pulses = 0;
        for (int c = 0; c < cycles; c++) begin
            @(negedge clk);
            if (done) pulses++;
        end
    endtask

    task automatic end_op();
        @(negedge clk);
        enable = 1'b0;
    endtask

    // Full operation with result and timing checks.
    task automatic run_check(input logic [23:0] k, input logic [127:0] m,
                             input logic [127:0] exp, input string req);
        int edges;
        begin_op(k, m);
        wait_done(edges);
        check(edges == LAT, "R5 latency", 128'(edges), 128'(LAT));
        check(msg_out === exp, req, msg_out, exp);
        @(negedge clk);
        check(done === 1'b0, "R5 single-cycle done", 128'(done), 128'h0);
        enable = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int edges, pulses;
        logic [127:0] held, exp_a, ct;

        // R9: reset state
        repeat (3) @(negedge clk);
        check(done === 1'b0, "R9 reset done", 128'(done), 128'h0);
        check(msg_out === '0, "R9 reset result", msg_out, 128'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2: published vector
        run_check(24'h010203, 128'h5745204C4F5645204543454E20333230,
                  128'h5c057e9fd5458ec36d7ef9cc4d22ea3e, "R2 known vector");

        // R1: table of vectors against the model
        for (int v = 0; v < 5; v++) begin
            run_check(VKEY[v], VMSG[v], model(VKEY[v], VMSG[v]), "R1 vector");
        end

        // R3: round trip with the same key
        ct = model(24'h3fe21b, 128'h5745204C4F5645204543454E20333230);
        run_check(24'h3fe21b, ct, 128'h5745204C4F5645204543454E20333230, "R3 round trip");

        // R4 and R6: hold enable high, change inputs, expect no start and a stable result
        begin_op(24'h0a0b0c, 128'h1111);
        wait_done(edges);
        held = msg_out;
        check(held === model(24'h0a0b0c, 128'h1111), "R1 hold setup", held,
              model(24'h0a0b0c, 128'h1111));
        @(negedge clk);
        key = 24'h123456; msg_in = {16{8'h77}};
        count_done(2000, pulses);
        check(pulses == 0, "R4 no restart while enable held", 128'(pulses), 128'h0);
        check(msg_out === held, "R6 result held", msg_out, held);
        end_op();

        // R7 and R8: change inputs and toggle enable mid-operation
        exp_a = model(24'hc0ffee, 128'hdeadbeef_00112233_44556677_8899aabb);
        begin_op(24'hc0ffee, 128'hdeadbeef_00112233_44556677_8899aabb);
        edges = 0;
        for (int c = 0; c < 100; c++) begin
            @(posedge clk); edges++;
            @(negedge clk);
        end
        key = 24'h111111; msg_in = '0; enable = 1'b0;
        for (int c = 0; c < 5; c++) begin
            @(posedge clk); edges++;
            @(negedge clk);
        end
        enable = 1'b1;
        begin
            int more;
            wait_done(more);
            edges = edges + more;
        end
        check(edges == LAT, "R8 latency unchanged by toggle", 128'(edges), 128'(LAT));
        check(msg_out === exp_a, "R7 captured inputs used", msg_out, exp_a);
        count_done(1300, pulses);
        check(pulses == 0, "R8 completes exactly once", 128'(pulses), 128'h0);
        end_op();

        // R9: reset in the middle of an operation
        begin_op(24'h445566, {16{8'h41}});
        repeat (500) @(negedge clk);
        enable = 1'b0; rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        count_done(1300, pulses);
        check(pulses == 0, "R9 abort leaves no done", 128'(pulses), 128'h0);
        check(msg_out === '0, "R9 abort clears result", msg_out, 128'h0);

        // R9: normal operation after reset
        run_check(24'h445566, {16{8'h41}}, model(24'h445566, {16{8'h41}}), "R9 recovery");

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule